// File: doc/BRIEF.md
# I2C Master Receive Byte Queue with Transfer Counter

This block sits between the serial bit engine of an I2C master receiver and the host-side data register. Every byte the bit engine finishes shifting in is offered with a one-cycle strobe and, when there is room, stored in a small first-in first-out queue. The host removes bytes one at a time with a pop strobe, and the popped byte stays on a registered read port until the next successful pop.

Next to the queue runs a remaining-byte counter. Software loads it with the size of the transfer, up to the counter width. Each byte accepted from the serial side lowers it by one, and a completion pulse marks the step to zero. The block tells the bit engine when it may end the transfer with a STOP: only when the count is spent and bus hold is off. While hold is on and the queue is full, a stall output makes the bit engine stretch the clock until the host frees a slot. A one-cycle threshold pulse warns the host when the queue is two entries short of full. Pushing into a full queue and popping from an empty one each raise their own error pulse.

Top module: `i2c_rxq_top`

## Requirements
- R1: After reset the queue is empty (level 0, data-available low), the read port is 0, the remaining count is 0, every event pulse is low, stall is low, and the STOP-permit output is high while hold is off.
- R2: Bytes leave in the order they were accepted. A pop of a non-empty queue puts the oldest byte on the read port in the cycle after the pop strobe, and the level drops by one.
- R3: The data-available output is high exactly when the level is nonzero.
- R4: The threshold pulse is high for one cycle, right after the edge at which the level becomes DEPTH-2 (14 by default) from a different value.
- R5: A byte offered while the queue is full and no pop occurs is dropped. The level stays put, the remaining count does not change, and the overflow pulse is high for one cycle.
- R6: A pop while the queue is empty raises the underflow pulse for one cycle. The read port keeps its previous value and the level stays 0.
- R7: A clear strobe empties the queue. A push or pop in the same cycle is discarded and raises no error pulse.
- R8: A load strobe sets the remaining count to the load value. Otherwise each accepted byte lowers a nonzero count by one, and a count of 0 stays at 0.
- R9: The completion pulse is high for one cycle after an accepted byte takes the count from 1 to 0.
- R10: When a load and an accepted byte fall in the same cycle, the count takes the load value.
- R11: Stall is high exactly when hold is on and the queue is full. It drops in the cycle after a pop that is not matched by a push.
- R12: The STOP-permit output is high exactly when the remaining count is 0 and hold is off.
- R13: A push and a pop in the same cycle on a full queue both take effect. The level stays at DEPTH and no overflow is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_valid_i | input | 1 | Bit engine offers a received byte |
| byte_i | input | DW | Received byte |
| host_pop_i | input | 1 | Host pops one byte |
| rd_data_o | output | DW | Last byte popped |
| fifo_clear_i | input | 1 | Empty the queue |
| size_load_i | input | 1 | Load the remaining-byte count |
| size_val_i | input | CW | Value to load |
| hold_en_i | input | 1 | Keep the bus held rather than issue STOP |
| level_o | output | $clog2(DEPTH+1) | Bytes in the queue |
| data_avail_o | output | 1 | At least one byte waiting |
| xfer_left_o | output | CW | Remaining-byte count |
| thresh_evt_o | output | 1 | Level just reached DEPTH-2 |
| done_evt_o | output | 1 | Count just reached zero |
| ovf_evt_o | output | 1 | Byte dropped on a full queue |
| unf_evt_o | output | 1 | Pop of an empty queue |
| stall_o | output | 1 | Bit engine must stretch the clock |
| stop_ok_o | output | 1 | Bit engine may end with STOP |

## Verification
The bench builds the block with its default parameters: a 16-entry byte queue with a threshold gap of 2 and an 8-bit counter. With these values, sixteen pushes reach the full and stall corners, fourteen reach the threshold, and small counter loads reach zero within a handful of bytes. A reference model in the bench predicts every output after each cycle. It covers queue order, drop on overflow, same-cycle push and pop on a full queue, clear against a same-cycle push, load against a same-cycle decrement, and the count saturating at zero.

// File: rtl/i2c_rxq_pkg.sv
package i2c_rxq_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_POP  = 2'b01,
        OP_PUSH = 2'b10,
        OP_BOTH = 2'b11
    } fifo_op_e;

endpackage

// File: rtl/i2c_rxq_fifo.sv
module i2c_rxq_fifo
    import i2c_rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int GAP   = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  logic [DW-1:0]                data_i,
    input  logic                         pop_i,
    input  logic                         clr_i,
    output logic [$clog2(DEPTH+1)-1:0]   level_o,
    output logic [DW-1:0]                rd_data_o,
    output logic                         accept_o,
    output logic                         full_o,
    output logic                         ovf_o,
    output logic                         unf_o,
    output logic                         thr_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH + 1);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
    localparam logic [LW-1:0] THR_LVL  = LW'(DEPTH - GAP);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [LW-1:0] lvl;
        logic [DW-1:0] dout;
        logic          ovf;
        logic          unf;
        logic          thr;
    } fifo_st_t;

    fifo_st_t    st_d, st_q;
    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];
    logic        full, empty, pop_ok, push_ok;
    fifo_op_e    op;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        mem_d   = mem_q;
        st_d.ovf = 1'b0;
        st_d.unf = 1'b0;
        st_d.thr = 1'b0;
        full    = (st_q.lvl == FULL_LVL);
        empty   = (st_q.lvl == '0);
        pop_ok  = pop_i & ~empty & ~clr_i;
        push_ok = push_i & ~clr_i & (~full | pop_ok);
        op      = fifo_op_e'({push_ok, pop_ok});
        if (clr_i) begin
            st_d.wr  = '0;
            st_d.rd  = '0;
            st_d.lvl = '0;
        end else begin
            st_d.unf = pop_i & empty;
            st_d.ovf = push_i & ~push_ok;
            if (push_ok) begin
                mem_d[st_q.wr] = data_i;
                st_d.wr        = ptr_next(st_q.wr);
            end
            if (pop_ok) begin
                st_d.dout = mem_q[st_q.rd];
                st_d.rd   = ptr_next(st_q.rd);
            end
            case (op)
                OP_PUSH: st_d.lvl = st_q.lvl + 1'b1;
                OP_POP:  st_d.lvl = st_q.lvl - 1'b1;
                default: st_d.lvl = st_q.lvl;
            endcase
            st_d.thr = (st_d.lvl == THR_LVL) && (st_q.lvl != THR_LVL);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign level_o   = st_q.lvl;
    assign rd_data_o = st_q.dout;
    assign accept_o  = push_ok;
    assign full_o    = full;
    assign ovf_o     = st_q.ovf;
    assign unf_o     = st_q.unf;
    assign thr_o     = st_q.thr;

    AST_OVF_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !pop_i && !clr_i) |=> (level_o == FULL_LVL && ovf_o)); // R5
    AST_UNF_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && level_o == '0 && !clr_i) |=> ($stable(rd_data_o) && unf_o)); // R6
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (level_o == '0 && !ovf_o && !unf_o)); // R7
    AST_THRESH_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        thr_o |-> (level_o == THR_LVL)); // R4
    AST_FULL_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && push_i && pop_i && !clr_i) |=> (level_o == FULL_LVL && !ovf_o)); // R13

endmodule

// File: rtl/i2c_rxq_count.sv
module i2c_rxq_count #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          dec_i,
    output logic [CW-1:0] count_o,
    output logic          done_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (load_i) begin
            st_d.cnt = load_val_i;
        end else if (dec_i && st_q.cnt != '0) begin
            st_d.cnt  = st_q.cnt - 1'b1;
            st_d.done = (st_q.cnt == CW'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.cnt;
    assign done_o  = st_q.done;

    AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (count_o == '0)); // R9
    AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == '0 && dec_i && !load_i) |=> (count_o == '0 && !done_o)); // R8
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (count_o == $past(load_val_i))); // R10

endmodule

// File: rtl/i2c_rxq_top.sv
module i2c_rxq_top #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int GAP   = 2,
    parameter int CW    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       byte_valid_i,
    input  logic [DW-1:0]              byte_i,
    input  logic                       host_pop_i,
    output logic [DW-1:0]              rd_data_o,
    input  logic                       fifo_clear_i,
    input  logic                       size_load_i,
    input  logic [CW-1:0]              size_val_i,
    input  logic                       hold_en_i,
    output logic [$clog2(DEPTH+1)-1:0] level_o,
    output logic                       data_avail_o,
    output logic [CW-1:0]              xfer_left_o,
    output logic                       thresh_evt_o,
    output logic                       done_evt_o,
    output logic                       ovf_evt_o,
    output logic                       unf_evt_o,
    output logic                       stall_o,
    output logic                       stop_ok_o
);
    logic accept_w;
    logic full_w;

    i2c_rxq_fifo #(.DEPTH(DEPTH), .DW(DW), .GAP(GAP)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (byte_valid_i),
        .data_i    (byte_i),
        .pop_i     (host_pop_i),
        .clr_i     (fifo_clear_i),
        .level_o   (level_o),
        .rd_data_o (rd_data_o),
        .accept_o  (accept_w),
        .full_o    (full_w),
        .ovf_o     (ovf_evt_o),
        .unf_o     (unf_evt_o),
        .thr_o     (thresh_evt_o)
    );

    i2c_rxq_count #(.CW(CW)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (size_load_i),
        .load_val_i (size_val_i),
        .dec_i      (accept_w),
        .count_o    (xfer_left_o),
        .done_o     (done_evt_o)
    );

    assign data_avail_o = (level_o != '0);
    assign stall_o      = hold_en_i & full_w;
    assign stop_ok_o    = (xfer_left_o == '0) & ~hold_en_i;

    AST_STALL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && host_pop_i && !byte_valid_i && !fifo_clear_i) |=> !stall_o); // R11
    AST_DROP_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (full_w && byte_valid_i && !host_pop_i && !size_load_i) |=> $stable(xfer_left_o)); // R5

endmodule

// File: tb/i2c_rxq_top_tb_top.sv
`timescale 1ns/1ps
module i2c_rxq_top_tb_top;
    localparam int DEPTH = 16;
    localparam int DW    = 8;
    localparam int CW    = 8;
    localparam int LW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic byte_valid = 0, host_pop = 0, fifo_clear = 0, size_load = 0, hold_en = 0;
    logic [DW-1:0] byte_in = '0;
    logic [CW-1:0] size_val = '0;
    logic [DW-1:0] rd_data;
    logic [LW-1:0] level;
    logic data_avail, thresh_evt, done_evt, ovf_evt, unf_evt, stall, stop_ok;
    logic [CW-1:0] xfer_left;

    int checks = 0;
    int failures = 0;

    logic [DW-1:0] exp_q[$];
    int m_lvl = 0;
    int m_cnt = 0;
    int m_data = 0;

    always #2.5 clk = ~clk;

    i2c_rxq_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .byte_valid_i(byte_valid), .byte_i(byte_in),
        .host_pop_i(host_pop), .rd_data_o(rd_data),
        .fifo_clear_i(fifo_clear), .size_load_i(size_load), .size_val_i(size_val),
        .hold_en_i(hold_en), .level_o(level), .data_avail_o(data_avail),
        .xfer_left_o(xfer_left), .thresh_evt_o(thresh_evt), .done_evt_o(done_evt),
        .ovf_evt_o(ovf_evt), .unf_evt_o(unf_evt), .stall_o(stall), .stop_ok_o(stop_ok)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, model the requirements, check at next negedge.
    task automatic step(input logic pu, input logic [7:0] b, input logic po,
                        input logic cl, input logic ld, input logic [7:0] lv);
        bit acc, pop_ok, e_ovf, e_unf, e_thr, e_done;
        int old_lvl;
        byte_valid = pu; byte_in = b; host_pop = po;
        fifo_clear = cl; size_load = ld; size_val = lv;
        old_lvl = m_lvl;
        e_ovf = 0; e_unf = 0; e_thr = 0; acc = 0; pop_ok = 0;
        if (cl) begin
            exp_q.delete();
            m_lvl = 0;
        end else begin
            pop_ok = po && (m_lvl > 0);
            e_unf  = po && (m_lvl == 0);
            acc    = pu && ((m_lvl < DEPTH) || pop_ok);
            e_ovf  = pu && !acc;
            if (pop_ok) m_data = exp_q.pop_front();
            if (acc) exp_q.push_back(b);
            m_lvl = exp_q.size();
            e_thr = (m_lvl == DEPTH - 2) && (old_lvl != DEPTH - 2);
        end
        e_done = 0;
        if (ld) m_cnt = lv;
        else if (acc && m_cnt > 0) begin
            e_done = (m_cnt == 1);
            m_cnt--;
        end
        @(posedge clk);
        @(negedge clk);
        byte_valid = 0; host_pop = 0; fifo_clear = 0; size_load = 0;
        chk("R2 level", int'(level), m_lvl);
        chk("R2 data", int'(rd_data), m_data);
        chk("R3 avail", int'(data_avail), int'(m_lvl != 0));
        chk("R4 thresh", int'(thresh_evt), int'(e_thr));
        chk("R5 ovf", int'(ovf_evt), int'(e_ovf));
        chk("R6 unf", int'(unf_evt), int'(e_unf));
        chk("R8 count", int'(xfer_left), m_cnt);
        chk("R9 done", int'(done_evt), int'(e_done));
        chk("R11 stall", int'(stall), int'(hold_en && m_lvl == DEPTH));
        chk("R12 stop", int'(stop_ok), int'(m_cnt == 0 && !hold_en));
    endtask

    initial begin
        #100000;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 level", int'(level), 0);
        chk("R1 avail", int'(data_avail), 0);
        chk("R1 data", int'(rd_data), 0);
        chk("R1 count", int'(xfer_left), 0);
        chk("R1 events", int'({thresh_evt, done_evt, ovf_evt, unf_evt}), 0);
        chk("R1 stall", int'(stall), 0);
        chk("R1 stop", int'(stop_ok), 1);

        step(0, 0, 0, 0, 1, 8'd20);
        step(1, 8'hA1, 0, 0, 0, 0);
        step(1, 8'hB2, 0, 0, 0, 0);
        step(1, 8'hC3, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);           // R6 pop of empty queue
        for (int i = 0; i < DEPTH; i++) step(1, 8'h10 + 8'(i), 0, 0, 0, 0);
        hold_en = 1;
        step(0, 0, 0, 0, 0, 0);           // R11 stall while full
        step(1, 8'hEE, 0, 0, 0, 0);       // R5 dropped byte
        step(1, 8'h55, 1, 0, 0, 0);       // R13 push and pop on full
        chk("R13 no ovf", int'(ovf_evt), 0);
        chk("R13 level", int'(level), DEPTH);
        step(0, 0, 1, 0, 0, 0);           // R11 release
        step(1, 8'h77, 0, 1, 0, 0);       // R7 clear beats push
        chk("R7 level", int'(level), 0);
        chk("R7 no ovf", int'(ovf_evt), 0);
        step(1, 8'h90, 0, 0, 1, 8'd2);    // R10 load beats decrement
        chk("R10 count", int'(xfer_left), 2);
        step(1, 8'h91, 0, 0, 0, 0);
        step(1, 8'h92, 0, 0, 0, 0);       // R9 reaches zero
        step(1, 8'h93, 0, 0, 0, 0);       // R8 saturate at zero
        hold_en = 0;
        while (exp_q.size() > 0) step(0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);           // R12 stop permitted
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule